// File: doc/BRIEF.md
# Register Context Loader

The block replays lists of register writes that software has left in system memory. Each list entry is eight bytes long. The first 32-bit word is the data value and the second word is the target register offset. The engine fetches the two words of an entry with a simple read master. It then issues one write of that value to that offset on an internal configuration bus, and only after that does it fetch the next entry.

Three lists can be loaded in one run. Two single-buffered sub-lists, one high priority and one low priority, share one base address. The low-priority entries follow straight after the last high-priority entry. A double-buffered list has its own base address. Software programs the bases and counts through a small register interface and sets the start bit. The engine walks the lists and clears the start bit itself when it finishes. A completion flag is raised for every list that had entries. A failed memory read or a failed register write stops the run and raises an error flag. A failed register write also captures the offending offset. An interrupt output combines the flags with their per-flag enable bits.

Top module: `ctxrep_engine`

## Requirements
- R1: After reset every readable register (0x00, 0x10, 0x14, 0x18, 0x1C, 0x20) reads zero, `irq` is low and neither master issues a request.
- R2: For each entry the word at the entry address is written as data to the register offset held in the word at entry address + 4. An entry's write is accepted before the next entry's read is issued, and the writes appear in list order.
- R3: Lists run high-priority first, from the single-buffer base (0x18). Low-priority comes next, from the single-buffer base + 8 × high-priority count. The double-buffer list runs last, from its base (0x10). A list whose count is zero is skipped.
- R4: The single-buffer count register at 0x1C holds the high-priority count in bits 15:0 and the low-priority count in bits 31:16. The double-buffer count sits in bits 15:0 of 0x14.
- R5: Control bit 0 is set only by software. The engine clears it when the last list finishes. At that point it sets bit 18 (high-priority done), bit 19 (low-priority done) and bit 17 (double-buffer done), each only for a list whose count was non-zero.
- R6: Status flags in control bits 22:16 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R7: `irq` is high exactly when some flag in bits 22:16 is set while its enable, 14 bit positions lower (bits 8:2), is also set.
- R8: Writes to 0x10, 0x14, 0x18 and 0x1C are ignored while bit 0 is set. A write of 0 to bit 0 during a run does not stop the run.
- R9: A read response with `mrd_err` set sets flag bit 16, clears bit 0 and ends the run. After that no further read or write is issued and no completion flag is set.
- R10: A write acknowledge with `rw_err` set sets flag bit 22, places that write's offset in register 0x20, clears bit 0 and ends the run.
- R11: Control bit 1 and the enables in bits 8:2 read back as written, in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| mrd_req | output | 1 | Memory read request, held until answered |
| mrd_addr | output | 32 | Memory read byte address |
| mrd_valid | input | 1 | Read response present |
| mrd_data | input | 32 | Read response word |
| mrd_err | input | 1 | Read response carries an error |
| rw_valid | output | 1 | Register write request, held until acknowledged |
| rw_addr | output | 32 | Register write offset |
| rw_data | output | 32 | Register write data |
| rw_ready | input | 1 | Register write acknowledged |
| rw_err | input | 1 | Acknowledge carries a bus error |
| irq | output | 1 | Interrupt |

## Verification
The bench aims at the low-priority start address. It runs once with high-priority entries in front and once with none. A design that takes the wrong base, or scales the high-priority count wrongly, writes the wrong values, and the scoreboard reports them. Skipped lists must raise no completion flag, and an all-zero run must still end. A stuck start bit or stray flags show up there. Errors in the middle of a list must stop traffic at once and latch the exact offset, so a design that runs on writes extra items or leaves bit 0 set. Writes to the bases and to bit 0 during a run, W1C with mixed ones and zeros, and irq gating by a single enable catch engines that abort, corrupt their lists or clear the wrong flags.

// File: rtl/ctxrep_pkg.sv
package ctxrep_pkg;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_DB_BASE = 8'h10;
    localparam logic [7:0] OFS_DB_CNT  = 8'h14;
    localparam logic [7:0] OFS_SB_BASE = 8'h18;
    localparam logic [7:0] OFS_SB_CNT  = 8'h1C;
    localparam logic [7:0] OFS_ERRADR  = 8'h20;

    // control bit positions
    localparam int BIT_RUN  = 0;
    localparam int BIT_ARB  = 1;
    localparam int IE_LO    = 2;
    localparam int NFLAG    = 7;
    localparam int FLAG_LO  = 16;

    // flag index inside the 7-bit flag vector (order fixed by the map)
    localparam int F_RDERR = 0;
    localparam int F_DBDON = 1;
    localparam int F_HPDON = 2;
    localparam int F_LPDON = 3;
    localparam int F_BUSER = 6;

    // list index, in processing order
    localparam logic [1:0] L_HP = 2'd0;
    localparam logic [1:0] L_LP = 2'd1;
    localparam logic [1:0] L_DB = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_RDVAL,
        S_RDOFS,
        S_WRITE,
        S_DONE
    } seq_st_e;

endpackage

// File: rtl/ctxrep_csr.sv
module ctxrep_csr
    import ctxrep_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           csr_wr,
    input  logic [RAW-1:0] csr_addr,
    input  logic [31:0]    csr_wdata,
    output logic [31:0]    csr_rdata,
    output logic           irq,
    output logic           go_o,
    output logic [AW-1:0]  db_base_o,
    output logic [AW-1:0]  sb_base_o,
    output logic [CW-1:0]  db_cnt_o,
    output logic [CW-1:0]  hp_cnt_o,
    output logic [CW-1:0]  lp_cnt_o,
    input  logic           fin_i,
    input  logic [2:0]     mask_i,
    input  logic           rd_fail_i,
    input  logic           bus_fail_i,
    input  logic [AW-1:0]  bus_addr_i
);

    typedef struct packed {
        logic             run;
        logic             arb;
        logic [NFLAG-1:0] ie;
        logic [NFLAG-1:0] fl;
        logic [AW-1:0]    db_base;
        logic [AW-1:0]    sb_base;
        logic [CW-1:0]    db_cnt;
        logic [CW-1:0]    hp_cnt;
        logic [CW-1:0]    lp_cnt;
        logic [AW-1:0]    err_addr;
    } csr_t;

    csr_t r_q, r_d;
    logic go_d;
    logic [RAW-1:0] a_w;

    assign a_w = csr_addr;

    always_comb begin
        r_d  = r_q;
        go_d = 1'b0;
        if (csr_wr && a_w == RAW'(OFS_CTRL)) begin
            r_d.arb = csr_wdata[BIT_ARB];
            r_d.ie  = csr_wdata[IE_LO +: NFLAG];
            r_d.fl  = r_q.fl & ~csr_wdata[FLAG_LO +: NFLAG];
            if (csr_wdata[BIT_RUN] && !r_q.run) begin
                r_d.run = 1'b1;
                go_d    = 1'b1;
            end
        end
        if (csr_wr && !r_q.run) begin
            case (a_w)
                RAW'(OFS_DB_BASE): r_d.db_base = csr_wdata[AW-1:0];
                RAW'(OFS_DB_CNT):  r_d.db_cnt  = csr_wdata[CW-1:0];
                RAW'(OFS_SB_BASE): r_d.sb_base = csr_wdata[AW-1:0];
                RAW'(OFS_SB_CNT): begin
                    r_d.hp_cnt = csr_wdata[CW-1:0];
                    r_d.lp_cnt = csr_wdata[16 +: CW];
                end
                default: ;
            endcase
        end
        // engine events win over a same-cycle software clear
        if (fin_i) begin
            r_d.run = 1'b0;
            if (mask_i[L_HP]) r_d.fl[F_HPDON] = 1'b1;
            if (mask_i[L_LP]) r_d.fl[F_LPDON] = 1'b1;
            if (mask_i[L_DB]) r_d.fl[F_DBDON] = 1'b1;
        end
        if (rd_fail_i) begin
            r_d.run          = 1'b0;
            r_d.fl[F_RDERR]  = 1'b1;
        end
        if (bus_fail_i) begin
            r_d.run          = 1'b0;
            r_d.fl[F_BUSER]  = 1'b1;
            r_d.err_addr     = bus_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        csr_rdata = '0;
        case (a_w)
            RAW'(OFS_CTRL): begin
                csr_rdata[BIT_RUN]            = r_q.run;
                csr_rdata[BIT_ARB]            = r_q.arb;
                csr_rdata[IE_LO +: NFLAG]     = r_q.ie;
                csr_rdata[FLAG_LO +: NFLAG]   = r_q.fl;
            end
            RAW'(OFS_DB_BASE): csr_rdata[AW-1:0] = r_q.db_base;
            RAW'(OFS_DB_CNT):  csr_rdata[CW-1:0] = r_q.db_cnt;
            RAW'(OFS_SB_BASE): csr_rdata[AW-1:0] = r_q.sb_base;
            RAW'(OFS_SB_CNT): begin
                csr_rdata[CW-1:0]  = r_q.hp_cnt;
                csr_rdata[16 +: CW] = r_q.lp_cnt;
            end
            RAW'(OFS_ERRADR):  csr_rdata[AW-1:0] = r_q.err_addr;
            default: ;
        endcase
    end

    assign irq       = |(r_q.fl & r_q.ie);
    assign go_o      = go_d;
    assign db_base_o = r_q.db_base;
    assign sb_base_o = r_q.sb_base;
    assign db_cnt_o  = r_q.db_cnt;
    assign hp_cnt_o  = r_q.hp_cnt;
    assign lp_cnt_o  = r_q.lp_cnt;

    // R8: list setup cannot move while a run is active
    p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.run |=> ($stable(r_q.db_base) && $stable(r_q.sb_base) &&
                     $stable(r_q.db_cnt) && $stable(r_q.hp_cnt) && $stable(r_q.lp_cnt)));

    // R5: the run bit only drops on an engine event
    p_hw_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.run) |-> $past(fin_i || rd_fail_i || bus_fail_i));

    // R10: a bus error leaves its flag and offset behind
    p_err_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fail_i |=> (r_q.fl[F_BUSER] && r_q.err_addr == $past(bus_addr_i)));

    // R5: completion with a high-priority list done raises its flag
    p_hp_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && mask_i[L_HP]) |=> r_q.fl[F_HPDON]);

endmodule

// File: rtl/ctxrep_seq.sv
module ctxrep_seq
    import ctxrep_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [AW-1:0] db_base_i,
    input  logic [AW-1:0] sb_base_i,
    input  logic [CW-1:0] db_cnt_i,
    input  logic [CW-1:0] hp_cnt_i,
    input  logic [CW-1:0] lp_cnt_i,
    output logic          mrd_req,
    output logic [AW-1:0] mrd_addr,
    input  logic          mrd_valid,
    input  logic [31:0]   mrd_data,
    input  logic          mrd_err,
    output logic          rw_valid,
    output logic [31:0]   rw_addr,
    output logic [31:0]   rw_data,
    input  logic          rw_ready,
    input  logic          rw_err,
    output logic          fin_o,
    output logic [2:0]    mask_o,
    output logic          rd_fail_o,
    output logic          bus_fail_o,
    output logic [AW-1:0] bus_addr_o
);

    localparam int ENT_SH  = 3;   // 8 bytes per entry
    localparam int WORD_B  = 4;

    typedef struct packed {
        seq_st_e       st;
        logic [1:0]    idx;
        logic [AW-1:0] ptr;
        logic [CW-1:0] rem;
        logic [31:0]   val;
        logic [31:0]   ofs;
        logic [2:0]    mask;
    } seq_t;

    seq_t s_q, s_d;
    logic [AW-1:0] lp_base;
    logic [AW-1:0] cur_base;
    logic [CW-1:0] cur_cnt;
    logic          rd_hit, wr_hit;

    // low-priority entries sit right behind the high-priority ones
    assign lp_base = sb_base_i + (AW'(hp_cnt_i) << ENT_SH);

    always_comb begin
        case (s_q.idx)
            L_HP:    begin cur_base = sb_base_i; cur_cnt = hp_cnt_i; end
            L_LP:    begin cur_base = lp_base;   cur_cnt = lp_cnt_i; end
            default: begin cur_base = db_base_i; cur_cnt = db_cnt_i; end
        endcase
    end

    assign rd_hit = (s_q.st == S_RDVAL || s_q.st == S_RDOFS) && mrd_valid;
    assign wr_hit = (s_q.st == S_WRITE) && rw_ready;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            S_IDLE: begin
                if (go_i) begin
                    s_d.st   = S_PICK;
                    s_d.idx  = L_HP;
                    s_d.mask = '0;
                end
            end
            S_PICK: begin
                if (cur_cnt == '0) begin
                    if (s_q.idx == L_DB) s_d.st  = S_DONE;
                    else                 s_d.idx = s_q.idx + 2'd1;
                end else begin
                    s_d.ptr = cur_base;
                    s_d.rem = cur_cnt;
                    s_d.st  = S_RDVAL;
                end
            end
            S_RDVAL: begin
                if (rd_hit) begin
                    if (mrd_err) s_d.st = S_IDLE;
                    else begin
                        s_d.val = mrd_data;
                        s_d.ptr = s_q.ptr + AW'(WORD_B);
                        s_d.st  = S_RDOFS;
                    end
                end
            end
            S_RDOFS: begin
                if (rd_hit) begin
                    if (mrd_err) s_d.st = S_IDLE;
                    else begin
                        s_d.ofs = mrd_data;
                        s_d.ptr = s_q.ptr + AW'(WORD_B);
                        s_d.st  = S_WRITE;
                    end
                end
            end
            S_WRITE: begin
                if (wr_hit) begin
                    if (rw_err) s_d.st = S_IDLE;
                    else begin
                        s_d.rem = s_q.rem - CW'(1);
                        if (s_q.rem == CW'(1)) begin
                            s_d.mask[s_q.idx] = 1'b1;
                            if (s_q.idx == L_DB) s_d.st = S_DONE;
                            else begin
                                s_d.idx = s_q.idx + 2'd1;
                                s_d.st  = S_PICK;
                            end
                        end else begin
                            s_d.st = S_RDVAL;
                        end
                    end
                end
            end
            S_DONE:  s_d.st = S_IDLE;
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign mrd_req    = (s_q.st == S_RDVAL) || (s_q.st == S_RDOFS);
    assign mrd_addr   = s_q.ptr;
    assign rw_valid   = (s_q.st == S_WRITE);
    assign rw_addr    = s_q.ofs;
    assign rw_data    = s_q.val;
    assign fin_o      = (s_q.st == S_DONE);
    assign mask_o     = s_q.mask;
    assign rd_fail_o  = rd_hit && mrd_err;
    assign bus_fail_o = wr_hit && rw_err;
    assign bus_addr_o = AW'(s_q.ofs);

    // R2: an unanswered read keeps its address
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && !mrd_valid) |=> (mrd_req && $stable(mrd_addr)));

    // R2: a register write starts only after the offset word arrived
    p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rw_valid) |-> $past(mrd_req && mrd_valid));

    // R2: reads and writes never overlap
    p_one_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mrd_req && rw_valid));

    // R9: a failed read ends all traffic
    p_rd_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fail_o |=> (!mrd_req && !rw_valid));

    // R10: a failed write ends all traffic
    p_wr_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fail_o |=> (!mrd_req && !rw_valid));

endmodule

// File: rtl/ctxrep_engine.sv
module ctxrep_engine
    import ctxrep_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           csr_wr,
    input  logic [RAW-1:0] csr_addr,
    input  logic [31:0]    csr_wdata,
    output logic [31:0]    csr_rdata,
    output logic           mrd_req,
    output logic [AW-1:0]  mrd_addr,
    input  logic           mrd_valid,
    input  logic [31:0]    mrd_data,
    input  logic           mrd_err,
    output logic           rw_valid,
    output logic [31:0]    rw_addr,
    output logic [31:0]    rw_data,
    input  logic           rw_ready,
    input  logic           rw_err,
    output logic           irq
);

    logic          go_w, fin_w, rd_fail_w, bus_fail_w;
    logic [2:0]    mask_w;
    logic [AW-1:0] db_base_w, sb_base_w, bus_addr_w;
    logic [CW-1:0] db_cnt_w, hp_cnt_w, lp_cnt_w;

    ctxrep_csr #(.AW(AW), .CW(CW), .RAW(RAW)) i_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_wr     (csr_wr),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .irq        (irq),
        .go_o       (go_w),
        .db_base_o  (db_base_w),
        .sb_base_o  (sb_base_w),
        .db_cnt_o   (db_cnt_w),
        .hp_cnt_o   (hp_cnt_w),
        .lp_cnt_o   (lp_cnt_w),
        .fin_i      (fin_w),
        .mask_i     (mask_w),
        .rd_fail_i  (rd_fail_w),
        .bus_fail_i (bus_fail_w),
        .bus_addr_i (bus_addr_w)
    );

    ctxrep_seq #(.AW(AW), .CW(CW)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_w),
        .db_base_i  (db_base_w),
        .sb_base_i  (sb_base_w),
        .db_cnt_i   (db_cnt_w),
        .hp_cnt_i   (hp_cnt_w),
        .lp_cnt_i   (lp_cnt_w),
        .mrd_req    (mrd_req),
        .mrd_addr   (mrd_addr),
        .mrd_valid  (mrd_valid),
        .mrd_data   (mrd_data),
        .mrd_err    (mrd_err),
        .rw_valid   (rw_valid),
        .rw_addr    (rw_addr),
        .rw_data    (rw_data),
        .rw_ready   (rw_ready),
        .rw_err     (rw_err),
        .fin_o      (fin_w),
        .mask_o     (mask_w),
        .rd_fail_o  (rd_fail_w),
        .bus_fail_o (bus_fail_w),
        .bus_addr_o (bus_addr_w)
    );

    // R1: nothing is requested right after reset
    p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mrd_req && !rw_valid && !irq));

endmodule

// File: tb/test_ctxrep_engine.sv
module test_ctxrep_engine;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [7:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_valid = 1'b0;
    logic [31:0] mrd_data = '0;
    logic        mrd_err = 1'b0;
    logic        rw_valid;
    logic [31:0] rw_addr, rw_data;
    logic        rw_ready = 1'b0;
    logic        rw_err = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;

    logic [31:0] mem [0:255];
    logic [63:0] exp_q [$];
    logic [31:0] bad_rd = 32'hFFFF_FFFF;
    logic [31:0] bad_wr = 32'hFFFF_FFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxrep_engine i_ctxrep_engine (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_valid(mrd_valid),
        .mrd_data(mrd_data), .mrd_err(mrd_err),
        .rw_valid(rw_valid), .rw_addr(rw_addr), .rw_data(rw_data),
        .rw_ready(rw_ready), .rw_err(rw_err), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // memory and register-bus responder plus scoreboard monitor
    always @(negedge clk) begin
        mrd_valid = mrd_req;
        mrd_data  = mem[mrd_addr[9:2]];
        mrd_err   = mrd_req && (mrd_addr == bad_rd);
        rw_ready  = rw_valid;
        rw_err    = rw_valid && (rw_addr == bad_wr);
        if (rw_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected write actual=%08h:%08h expected=none",
                         rw_addr, rw_data);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                if ({rw_addr, rw_data} !== e) begin
                    bad++;
                    $display("FAIL R2/R3 write actual=%08h:%08h expected=%08h:%08h",
                             rw_addr, rw_data, e[63:32], e[31:0]);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic put(input logic [31:0] base, input int i, input logic [31:0] v,
                       input logic [31:0] o, input bit expect_it);
        mem[(base >> 2) + 2*i]     = v;
        mem[(base >> 2) + 2*i + 1] = o;
        if (expect_it) exp_q.push_back({o, v});
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] c;
        int n;
        n = 0;
        c = 32'h1;
        while (c[0] && n < 2000) begin
            rd(8'h00, c);
            n++;
        end
        chk({req, " run bit cleared"}, {31'd0, c[0]}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h10, v); chk("R1 db base", v, 32'h0);
        rd(8'h14, v); chk("R1 db cnt", v, 32'h0);
        rd(8'h18, v); chk("R1 sb base", v, 32'h0);
        rd(8'h1C, v); chk("R1 sb cnt", v, 32'h0);
        rd(8'h20, v); chk("R1 err addr", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 no read", {31'd0, mrd_req}, 32'd0);
        chk("R1 no write", {31'd0, rw_valid}, 32'd0);

        // R11: arb bit and enables read back
        wr(8'h00, 32'h0000_01FE);
        rd(8'h00, v); chk("R11 ctrl readback", v, 32'h0000_01FE);

        // run 1: hp=2, lp=1, db=2 (R2 R3 R4 R5)
        put(32'h100, 0, 32'hA000_0001, 32'h0000_1000, 1);
        put(32'h100, 1, 32'hA000_0002, 32'h0000_1004, 1);
        put(32'h100, 2, 32'hB000_0001, 32'h0000_2000, 1);
        put(32'h100, 3, 32'hBEEF_BEEF, 32'h0000_2FFF, 0);
        put(32'h200, 0, 32'hC000_0001, 32'h0000_3000, 0);
        put(32'h200, 1, 32'hC000_0002, 32'h0000_3004, 0);
        exp_q.push_back({32'h0000_3000, 32'hC000_0001});
        exp_q.push_back({32'h0000_3004, 32'hC000_0002});
        wr(8'h18, 32'h100);
        wr(8'h10, 32'h200);
        wr(8'h14, 32'h2);
        wr(8'h1C, 32'h0001_0002);
        rd(8'h1C, v); chk("R4 sb count fields", v, 32'h0001_0002);
        rd(8'h14, v); chk("R4 db count field", v, 32'h0000_0002);
        wr(8'h00, 32'h0000_01FD);
        // R8: changes while running are ignored, a 0 in bit 0 does not abort
        wr(8'h10, 32'h280);
        wr(8'h1C, 32'h0000_0005);
        wr(8'h00, 32'h0000_01FC);
        rd(8'h00, v); chk("R8 run survives bit0=0", {31'd0, v[0]}, 32'd1);
        wait_idle("R5");
        rd(8'h10, v); chk("R8 db base kept", v, 32'h200);
        rd(8'h1C, v); chk("R8 sb count kept", v, 32'h0001_0002);
        chk("R2 all writes seen", exp_q.size(), 32'd0);
        rd(8'h00, v); chk("R5 done flags", v, 32'h000E_01FC);
        chk("R7 irq on", {31'd0, irq}, 32'd1);

        // R6: W1C
        wr(8'h00, 32'h0002_01FC);
        rd(8'h00, v); chk("R6 clear one flag", v, 32'h000C_01FC);
        wr(8'h00, 32'h000C_01FC);
        rd(8'h00, v); chk("R6 clear rest", v, 32'h0000_01FC);
        chk("R7 irq off", {31'd0, irq}, 32'd0);

        // run 2: only lp, starts at sb base (R3), irq gated by enables (R7)
        put(32'h100, 0, 32'h5100_0001, 32'h0000_4000, 1);
        put(32'h100, 1, 32'h5100_0002, 32'h0000_4004, 1);
        wr(8'h10, 32'h200);
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'h0002_0000);
        wr(8'h00, 32'h0000_0010);
        wr(8'h00, 32'h0000_0011);
        wait_idle("R3");
        chk("R3 lp writes seen", exp_q.size(), 32'd0);
        rd(8'h00, v); chk("R5 only lp flag", v, 32'h0008_0010);
        chk("R7 irq masked", {31'd0, irq}, 32'd0);
        wr(8'h00, 32'h0000_0030);
        chk("R7 irq enabled", {31'd0, irq}, 32'd1);
        wr(8'h00, 32'h0008_0030);

        // run 3: read error on entry 1 offset word (R9)
        put(32'h100, 0, 32'h7000_0001, 32'h0000_5000, 1);
        put(32'h100, 1, 32'h7000_0002, 32'h0000_5004, 0);
        put(32'h100, 2, 32'h7000_0003, 32'h0000_5008, 0);
        bad_rd = 32'h10C;
        wr(8'h1C, 32'h0000_0003);
        wr(8'h00, 32'h0000_01FD);
        wait_idle("R9");
        repeat (4) @(negedge clk);
        chk("R9 no writes after error", exp_q.size(), 32'd0);
        rd(8'h00, v); chk("R9 read error flag only", v, 32'h0001_01FC);
        chk("R9 irq", {31'd0, irq}, 32'd1);
        bad_rd = 32'hFFFF_FFFF;
        wr(8'h00, 32'h0001_01FC);

        // run 4: bus error on second db write (R10)
        put(32'h200, 0, 32'h9000_0001, 32'h0000_6000, 1);
        put(32'h200, 1, 32'h9000_0002, 32'h0000_BAD0, 1);
        put(32'h200, 2, 32'h9000_0003, 32'h0000_6008, 0);
        bad_wr = 32'h0000_BAD0;
        wr(8'h1C, 32'h0);
        wr(8'h14, 32'h3);
        wr(8'h00, 32'h0000_01FD);
        wait_idle("R10");
        repeat (4) @(negedge clk);
        chk("R10 writes until error", exp_q.size(), 32'd0);
        rd(8'h00, v); chk("R10 bus error flag", v, 32'h0040_01FC);
        rd(8'h20, v); chk("R10 captured offset", v, 32'h0000_BAD0);
        bad_wr = 32'hFFFF_FFFF;
        wr(8'h00, 32'h0040_01FC);

        // run 5: all counts zero (R3 R5)
        wr(8'h14, 32'h0);
        wr(8'h00, 32'h0000_01FD);
        wait_idle("R5 empty");
        rd(8'h00, v); chk("R5 no flags for empty run", v, 32'h0000_01FC);
        chk("R3 nothing written", exp_q.size(), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule